// File: doc/BRIEF.md
# Peripheral DMA Channel Engine

This block is one data-movement channel for a peripheral DMA system. It copies data elements between one peripheral data register and a dual-port buffer RAM on a bus of its own, so the processor never stalls for the copy. Each element moves in two cycles. In the first cycle the channel reads from the source side. In the second cycle it writes the data returned by that read to the destination side.

Static configuration inputs fix how the channel works:
- the transfer direction;
- word or byte element size;
- whether the RAM address post-increments;
- the block mode, which is one-shot, continuous reload, or ping-pong between two buffers;
- the two buffer start addresses;
- the block length, programmed as N−1;
- the request number that triggers a transfer.

Software arms the channel with a one-cycle enable pulse. After that, each rising edge on the selected request line, or a manual force pulse, moves one element. A one-cycle interrupt pulse marks either the end of a block or its half-way point.

Top module: `pdma_channel`

## Requirements
- R1: After reset `chan_en`, `force_pend`, `irq`, `pp_last` and all four bus strobes are 0.
- R2: Each accepted trigger produces one source-read cycle followed immediately by one destination-write cycle. With `cfg_dir`=0 the read is on the peripheral side (`per_rd`) and the write is on the RAM side (`ram_wr`). With `cfg_dir`=1 the read is `ram_rd` and the write is `per_wr`. `ram_addr` carries the element address in both cycles.
- R3: A word transfer (`cfg_byte`=0) passes all 16 bits, with byte enables 2'b11 on both sides. A byte transfer uses peripheral lane [7:0], with `per_be`=2'b01. It uses RAM lane [15:8] when `ram_addr[0]`=1 and lane [7:0] when `ram_addr[0]`=0, so `ram_be` is 2'b10 or 2'b01. A byte written to RAM is copied onto both lanes, and a byte written to the peripheral has zero in its upper byte.
- R4: Within a block, when `cfg_inc`=1 the address advances after each element by 2 for words and by 1 for bytes. When `cfg_inc`=0 it stays put.
- R5: `req_bus` is indexed by request number (0..71). A trigger is a rising edge on `req_bus[cfg_irq_sel]`, and only if that number is one of 0, 1, 2, 5, 6, 7, 8, 10, 11, 12, 13, 21, 30, 31, 33, 34, 55, 70, 71. Edges on any other number, or on a line that is not selected, cause no transfer.
- R6: A `force_set` pulse sets `force_pend`. That bit stays set, also while the channel is disabled, until a transfer is accepted. It clears at the edge where the source-read cycle starts.
- R7: One-shot mode (`cfg_mode`=0): `chan_en` drops at the end of the write cycle of the block's last element. Later triggers cause no bus activity.
- R8: Continuous mode (`cfg_mode`=1 or 3): after the last element, the address reloads to `cfg_start_a`, the count restarts and `chan_en` stays 1.
- R9: Ping-pong mode (`cfg_mode`=2): blocks alternate between `cfg_start_a` and `cfg_start_b`, beginning with A. At each block end `pp_last` shows the buffer just finished, with 0 meaning A and 1 meaning B.
- R10: With `cfg_half`=0, `irq` pulses for exactly one cycle, in the cycle after the write cycle of the block's last element.
- R11: With `cfg_half`=1, `irq` pulses once per block, in the cycle after the write cycle that completes element floor(N/2), where N = `cfg_count`+1. There is no pulse at block end, and no pulse at all when N=1.
- R12: An `en_set` pulse while idle sets `chan_en`, loads `cfg_start_a`, clears the element count and selects buffer A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir | input | 1 | 0: peripheral to RAM, 1: RAM to peripheral |
| cfg_byte | input | 1 | 1: byte elements, 0: word elements |
| cfg_inc | input | 1 | RAM address post-increment enable |
| cfg_mode | input | 2 | 0 one-shot, 1/3 continuous, 2 ping-pong |
| cfg_half | input | 1 | Interrupt at half block instead of block end |
| cfg_start_a | input | AW | Buffer A start address (byte address) |
| cfg_start_b | input | AW | Buffer B start address (byte address) |
| cfg_count | input | CW | Block length minus one |
| cfg_irq_sel | input | 7 | Request number that triggers transfers |
| en_set | input | 1 | Arm pulse |
| force_set | input | 1 | Manual transfer request pulse |
| req_bus | input | 72 | Request lines indexed by request number |
| ram_addr | output | AW | RAM byte address |
| ram_rd | output | 1 | RAM read strobe |
| ram_rdata | input | 16 | RAM read data, valid the cycle after `ram_rd` |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 16 | RAM write data |
| ram_be | output | 2 | RAM byte enables |
| per_rd | output | 1 | Peripheral read strobe |
| per_rdata | input | 16 | Peripheral read data, valid the cycle after `per_rd` |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | 16 | Peripheral write data |
| per_be | output | 2 | Peripheral byte enables |
| chan_en | output | 1 | Channel enabled |
| force_pend | output | 1 | Manual request pending |
| irq | output | 1 | Interrupt pulse |
| pp_last | output | 1 | Buffer that just completed |

## Verification
Several configurations drive the channel:
- A continuous word copy from the peripheral, started by a supported request number, shows the address reload and that a block-end interrupt appears once per block.
- Edges on an unsupported number, and on a supported number that is not selected, are set against real triggers to separate the request filtering from the edge detection.
- A one-shot byte copy to the peripheral from an odd start address, in half-interrupt mode, separates the two byte lanes, the step of 1, the floor(N/2) interrupt point and the self-disable.
- Forced transfers issued while the channel is disabled, and then with post-increment off, separate a held force from a dropped one and a held address from a stepped one.
- Ping-pong blocks of two elements show the alternation of the start address and the buffer flag.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;

   typedef enum logic [1:0] {
      MODE_ONCE = 2'd0,
      MODE_CONT = 2'd1,
      MODE_PP   = 2'd2,
      MODE_ALT  = 2'd3
   } blk_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } xfer_st_e;

   // request numbers that may trigger a transfer
   function automatic logic req_supported(input logic [6:0] n);
      case (n)
         7'd0, 7'd1, 7'd2, 7'd5, 7'd6, 7'd7, 7'd8, 7'd10, 7'd11, 7'd12,
         7'd13, 7'd21, 7'd30, 7'd31, 7'd33, 7'd34, 7'd55, 7'd70, 7'd71:
            req_supported = 1'b1;
         default:
            req_supported = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/pdma_trig.sv
`timescale 1ns/1ps
module pdma_trig #(
   parameter int NREQ     = 72,
   parameter int SELW     = 7,
   parameter bit REQ_EDGE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] req_bus,
   input  logic [SELW-1:0] sel,
   input  logic            force_set,
   input  logic            accept,
   output logic            pend,
   output logic            force_pend
);
   import pdma_pkg::*;

   logic sel_line;
   logic hit;

   always_comb begin
      sel_line = 1'b0;
      if (int'(sel) < NREQ) sel_line = req_bus[sel];
   end

   generate
      if (REQ_EDGE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sel_line;
         end
         assign hit = sel_line & ~prev_q & req_supported(sel);
      end else begin : g_level
         assign hit = sel_line & req_supported(sel);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         force_pend <= 1'b0;
      end else begin
         pend       <= hit | (pend & ~accept);
         force_pend <= force_set | (force_pend & ~accept);
      end
   end

endmodule

// File: rtl/pdma_addr.sv
`timescale 1ns/1ps
module pdma_addr #(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_a,
   input  logic          ld_b,
   input  logic          step,
   input  logic          byte_mode,
   input  logic          inc_en,
   input  logic [AW-1:0] start_a,
   input  logic [AW-1:0] start_b,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] STEP_W = AW'(2);
   localparam logic [AW-1:0] STEP_B = AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                addr <= '0;
      else if (ld_a)             addr <= start_a;
      else if (ld_b)             addr <= start_b;
      else if (step && inc_en)   addr <= addr + (byte_mode ? STEP_B : STEP_W);
   end

endmodule

// File: rtl/pdma_ctl.sv
`timescale 1ns/1ps
module pdma_ctl #(
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_set,
   input  logic          trig_any,
   input  logic [1:0]    cfg_mode,
   input  logic          cfg_half,
   input  logic [CW-1:0] cfg_count,
   output logic [1:0]    st,
   output logic          accept,
   output logic          chan_en,
   output logic          irq,
   output logic          pp_last,
   output logic          ld_a,
   output logic          ld_b,
   output logic          step
);
   import pdma_pkg::*;

   xfer_st_e      st_q;
   logic [CW-1:0] cnt_q;
   logic          buf_q;
   logic [CW:0]   n_full, n_half, n_done;
   logic          last_elem, irq_hit, wr_cyc, arm;

   assign st       = st_q;
   assign wr_cyc   = (st_q == ST_WR);
   assign arm      = en_set & (st_q == ST_IDLE);
   assign accept   = (st_q == ST_IDLE) & chan_en & trig_any;
   assign n_full   = {1'b0, cfg_count} + 1'b1;
   assign n_half   = n_full >> 1;
   assign n_done   = {1'b0, cnt_q} + 1'b1;
   assign last_elem = (cnt_q == cfg_count);
   assign irq_hit  = cfg_half ? ((n_half != '0) && (n_done == n_half)) : last_elem;

   always_comb begin
      ld_a = arm;
      ld_b = 1'b0;
      step = 1'b0;
      if (wr_cyc) begin
         if (last_elem) begin
            if (blk_mode_e'(cfg_mode) == MODE_PP && !buf_q) ld_b = 1'b1;
            else                                            ld_a = 1'b1;
         end else begin
            step = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         buf_q   <= 1'b0;
         chan_en <= 1'b0;
         irq     <= 1'b0;
         pp_last <= 1'b0;
      end else begin
         irq <= wr_cyc & irq_hit;
         case (st_q)
            ST_IDLE: begin
               if (arm) begin
                  chan_en <= 1'b1;
                  cnt_q   <= '0;
                  buf_q   <= 1'b0;
               end
               if (accept) st_q <= ST_RD;
            end
            ST_RD: st_q <= ST_WR;
            default: begin
               st_q <= ST_IDLE;
               if (last_elem) begin
                  cnt_q   <= '0;
                  pp_last <= buf_q;
                  if (blk_mode_e'(cfg_mode) == MODE_ONCE) chan_en <= 1'b0;
                  if (blk_mode_e'(cfg_mode) == MODE_PP)   buf_q   <= ~buf_q;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/pdma_channel.sv
`timescale 1ns/1ps
module pdma_channel #(
   parameter int AW       = 12,
   parameter int CW       = 10,
   parameter int NREQ     = 72,
   parameter bit REQ_EDGE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_dir,
   input  logic            cfg_byte,
   input  logic            cfg_inc,
   input  logic [1:0]      cfg_mode,
   input  logic            cfg_half,
   input  logic [AW-1:0]   cfg_start_a,
   input  logic [AW-1:0]   cfg_start_b,
   input  logic [CW-1:0]   cfg_count,
   input  logic [6:0]      cfg_irq_sel,
   input  logic            en_set,
   input  logic            force_set,
   input  logic [NREQ-1:0] req_bus,
   output logic [AW-1:0]   ram_addr,
   output logic            ram_rd,
   input  logic [15:0]     ram_rdata,
   output logic            ram_wr,
   output logic [15:0]     ram_wdata,
   output logic [1:0]      ram_be,
   output logic            per_rd,
   input  logic [15:0]     per_rdata,
   output logic            per_wr,
   output logic [15:0]     per_wdata,
   output logic [1:0]      per_be,
   output logic            chan_en,
   output logic            force_pend,
   output logic            irq,
   output logic            pp_last
);
   import pdma_pkg::*;

   localparam int SELW = 7;

   if (AW < 2)     begin : g_bad_aw   $error("AW must be at least 2");   end
   if (CW < 1)     begin : g_bad_cw   $error("CW must be at least 1");   end
   if (NREQ < 72)  begin : g_bad_nreq $error("NREQ must cover 0..71"); end

   logic       pend, accept, ld_a, ld_b, step;
   logic [1:0] st;
   logic       rd_cyc, wr_cyc, hi_lane;
   logic [7:0] ram_byte;

   pdma_trig #(.NREQ(NREQ), .SELW(SELW), .REQ_EDGE(REQ_EDGE)) u_trig (
      .clk(clk), .rst_n(rst_n), .req_bus(req_bus), .sel(cfg_irq_sel),
      .force_set(force_set), .accept(accept), .pend(pend), .force_pend(force_pend)
   );

   pdma_ctl #(.CW(CW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .en_set(en_set), .trig_any(pend | force_pend),
      .cfg_mode(cfg_mode), .cfg_half(cfg_half), .cfg_count(cfg_count),
      .st(st), .accept(accept), .chan_en(chan_en), .irq(irq), .pp_last(pp_last),
      .ld_a(ld_a), .ld_b(ld_b), .step(step)
   );

   pdma_addr #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .ld_a(ld_a), .ld_b(ld_b), .step(step),
      .byte_mode(cfg_byte), .inc_en(cfg_inc), .start_a(cfg_start_a),
      .start_b(cfg_start_b), .addr(ram_addr)
   );

   assign rd_cyc   = (st == ST_RD);
   assign wr_cyc   = (st == ST_WR);
   assign hi_lane  = ram_addr[0];
   assign ram_byte = hi_lane ? ram_rdata[15:8] : ram_rdata[7:0];

   assign ram_rd = rd_cyc &  cfg_dir;
   assign per_rd = rd_cyc & ~cfg_dir;
   assign ram_wr = wr_cyc & ~cfg_dir;
   assign per_wr = wr_cyc &  cfg_dir;

   always_comb begin
      if (cfg_byte) begin
         ram_wdata = {per_rdata[7:0], per_rdata[7:0]};
         ram_be    = hi_lane ? 2'b10 : 2'b01;
         per_wdata = {8'h00, ram_byte};
         per_be    = 2'b01;
      end else begin
         ram_wdata = per_rdata;
         ram_be    = 2'b11;
         per_wdata = ram_rdata;
         per_be    = 2'b11;
      end
   end

endmodule

// File: rtl/pdma_channel_chk.sv
`timescale 1ns/1ps
module pdma_channel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_mode,
   input logic       cfg_half,
   input logic       cfg_byte,
   input logic       ram_rd,
   input logic       per_rd,
   input logic       ram_wr,
   input logic       per_wr,
   input logic [1:0] ram_be,
   input logic       irq,
   input logic       chan_en,
   input logic       force_pend
);
   p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd || per_rd) |=> (ram_wr || per_wr));

   p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ram_rd, per_rd, ram_wr, per_wr}) <= 1);

   p_byte_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_wr && cfg_byte) |-> ($countones(ram_be) == 1));

   p_start_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd || per_rd) |-> $past(chan_en));

   p_force_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(force_pend) |-> (ram_rd || per_rd));

   p_irq_after_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(ram_wr || per_wr));

   p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_once_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && cfg_mode == 2'd0 && !cfg_half) |-> !chan_en);
endmodule

bind pdma_channel pdma_channel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_half(cfg_half),
   .cfg_byte(cfg_byte), .ram_rd(ram_rd), .per_rd(per_rd), .ram_wr(ram_wr),
   .per_wr(per_wr), .ram_be(ram_be), .irq(irq), .chan_en(chan_en),
   .force_pend(force_pend)
);

// File: tb/tb_pdma_channel.sv
`timescale 1ns/1ps
module tb_pdma_channel;
   localparam int AW = 12;
   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_dir = 0, cfg_byte = 0, cfg_inc = 1, cfg_half = 0;
   logic [1:0]    cfg_mode = 0;
   logic [AW-1:0] cfg_start_a = 0, cfg_start_b = 0;
   logic [CW-1:0] cfg_count = 0;
   logic [6:0]    cfg_irq_sel = 0;
   logic          en_set = 0, force_set = 0;
   logic [71:0]   req_bus = '0;
   logic [AW-1:0] ram_addr;
   logic          ram_rd, ram_wr, per_rd, per_wr;
   logic [15:0]   ram_rdata = 0, ram_wdata, per_rdata = 0, per_wdata;
   logic [1:0]    ram_be, per_be;
   logic          chan_en, force_pend, irq, pp_last;

   always #4 clk = ~clk;

   pdma_channel dut (.*);

   int n_chk = 0, n_bad = 0;
   int n_wr = 0, n_irq = 0;
   logic [AW-1:0] last_wr_addr = 0;
   logic [15:0]   mem [0:2047];
   logic [15:0]   per_val = 16'h1000;

   // bench memories
   always @(posedge clk) begin
      if (ram_rd) ram_rdata <= mem[ram_addr[AW-1:1]];
      if (ram_wr) begin
         if (ram_be[0]) mem[ram_addr[AW-1:1]][7:0]  <= ram_wdata[7:0];
         if (ram_be[1]) mem[ram_addr[AW-1:1]][15:8] <= ram_wdata[15:8];
      end
      if (per_rd) begin
         per_rdata <= per_val;
         per_val   <= per_val + 16'h0111;
      end
   end

   function automatic bit ok_num(input int n);
      int lst[19] = '{71, 70, 55, 34, 33, 31, 30, 21, 13, 12, 11, 10, 8, 7, 6, 5, 2, 1, 0};
      foreach (lst[i]) if (lst[i] == n) return 1'b1;
      return 1'b0;
   endfunction

   // behavioural reference model
   int            m_st = 0, m_cnt = 0;
   bit            m_en = 0, m_pend = 0, m_force = 0, m_prev = 0, m_buf = 0, m_last = 0, m_irq = 0;
   logic [AW-1:0] m_addr = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_en = 0; m_pend = 0; m_force = 0;
         m_prev = 0; m_buf = 0; m_last = 0; m_irq = 0; m_addr = 0;
      end else begin
         bit hit, acc, irq_n;
         int n, done;
         hit = req_bus[cfg_irq_sel] && !m_prev && ok_num(int'(cfg_irq_sel));
         m_prev = req_bus[cfg_irq_sel];
         acc = (m_st == 0) && m_en && (m_pend || m_force);
         irq_n = 0;
         if (m_st == 0) begin
            if (en_set) begin m_en = 1; m_addr = cfg_start_a; m_cnt = 0; m_buf = 0; end
            if (acc) m_st = 1;
         end else if (m_st == 1) begin
            m_st = 2;
         end else begin
            m_st = 0;
            n = int'(cfg_count) + 1;
            done = m_cnt + 1;
            irq_n = cfg_half ? ((n / 2 != 0) && (done == n / 2)) : (done == n);
            if (done == n) begin
               m_cnt = 0; m_last = m_buf;
               if (cfg_mode == 0) begin m_en = 0; m_addr = cfg_start_a; end
               else if (cfg_mode == 2) begin m_addr = m_buf ? cfg_start_a : cfg_start_b; m_buf = !m_buf; end
               else m_addr = cfg_start_a;
            end else begin
               m_cnt = done;
               if (cfg_inc) m_addr = m_addr + (cfg_byte ? 1 : 2);
            end
         end
         m_pend  = hit || (m_pend && !acc);
         m_force = force_set || (m_force && !acc);
         m_irq   = irq_n;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [15:0] e_rw, e_pw;
         logic [1:0]  e_rbe;
         chk(ram_rd == (m_st == 1 && cfg_dir),  "R2 ram_rd", 32'(ram_rd), 32'(m_st == 1 && cfg_dir));
         chk(per_rd == (m_st == 1 && !cfg_dir), "R2 per_rd", 32'(per_rd), 32'(m_st == 1 && !cfg_dir));
         chk(ram_wr == (m_st == 2 && !cfg_dir), "R2 ram_wr", 32'(ram_wr), 32'(m_st == 2 && !cfg_dir));
         chk(per_wr == (m_st == 2 && cfg_dir),  "R2 per_wr", 32'(per_wr), 32'(m_st == 2 && cfg_dir));
         if (m_st != 0) chk(ram_addr == m_addr, "R4 ram_addr", 32'(ram_addr), 32'(m_addr));
         e_rw  = cfg_byte ? {per_rdata[7:0], per_rdata[7:0]} : per_rdata;
         e_rbe = cfg_byte ? (m_addr[0] ? 2'b10 : 2'b01) : 2'b11;
         e_pw  = cfg_byte ? {8'h00, (m_addr[0] ? ram_rdata[15:8] : ram_rdata[7:0])} : ram_rdata;
         if (ram_wr) begin
            chk(ram_wdata == e_rw, "R3 ram_wdata", 32'(ram_wdata), 32'(e_rw));
            chk(ram_be == e_rbe,   "R3 ram_be",    32'(ram_be),    32'(e_rbe));
         end
         if (per_wr) begin
            chk(per_wdata == e_pw, "R3 per_wdata", 32'(per_wdata), 32'(e_pw));
            chk(per_be == (cfg_byte ? 2'b01 : 2'b11), "R3 per_be", 32'(per_be), 32'(cfg_byte ? 2'b01 : 2'b11));
         end
         chk(irq == m_irq,          "R10/R11 irq",   32'(irq),        32'(m_irq));
         chk(chan_en == m_en,       "R7/R12 chan_en", 32'(chan_en),   32'(m_en));
         chk(force_pend == m_force, "R6 force_pend", 32'(force_pend), 32'(m_force));
         chk(pp_last == m_last,     "R9 pp_last",    32'(pp_last),    32'(m_last));
         if (ram_wr || per_wr) begin n_wr++; last_wr_addr = ram_addr; end
         if (irq) n_irq++;
      end
   end

   task automatic req_pulse(input int n);
      @(negedge clk) req_bus[n] = 1'b1;
      @(negedge clk) req_bus[n] = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic force_pulse();
      @(negedge clk) force_set = 1'b1;
      @(negedge clk) force_set = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic arm();
      @(negedge clk) en_set = 1'b1;
      @(negedge clk) en_set = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   bit finished = 0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired act=1 exp=0");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int w0, i0;
      for (int i = 0; i < 2048; i++) mem[i] = 16'(i * 37 + 16'h5A0F);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({chan_en, force_pend, irq, pp_last, ram_rd, ram_wr, per_rd, per_wr} == 8'h00,
          "R1 reset outputs", 32'({chan_en, force_pend, irq, pp_last, ram_rd, ram_wr, per_rd, per_wr}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // continuous word copy from peripheral, request 11, N=4 (R2 R8 R10 R12)
      cfg_dir = 0; cfg_byte = 0; cfg_inc = 1; cfg_mode = 2'd1; cfg_half = 0;
      cfg_start_a = 12'h100; cfg_count = 10'd3; cfg_irq_sel = 7'd11;
      arm();
      chk(chan_en == 1'b1, "R12 arm sets chan_en", 32'(chan_en), 1);
      for (int k = 0; k < 8; k++) req_pulse(11);
      chk(n_wr == 8, "R8 continuous element count", n_wr, 8);
      chk(n_irq == 2, "R10 one irq per block", n_irq, 2);
      chk(chan_en == 1'b1, "R8 stays enabled", 32'(chan_en), 1);
      chk(mem[12'h100 >> 1] == 16'h1444 && mem[12'h106 >> 1] == 16'h1777,
          "R8 reloaded buffer holds second block", 32'(mem[12'h100 >> 1]), 32'h1444);

      // unsupported and unselected numbers (R5)
      w0 = n_wr;
      cfg_irq_sel = 7'd3;
      req_pulse(3);
      cfg_irq_sel = 7'd11;
      req_pulse(12);
      chk(n_wr == w0, "R5 ignored request numbers", n_wr, w0);
      cfg_irq_sel = 7'd71;
      req_pulse(71);
      chk(n_wr == w0 + 1, "R5 number 71 triggers", n_wr, w0 + 1);

      // one-shot byte copy to peripheral, odd start, half irq, N=5 (R3 R4 R7 R11)
      cfg_dir = 1; cfg_byte = 1; cfg_mode = 2'd0; cfg_half = 1;
      cfg_start_a = 12'h201; cfg_count = 10'd4; cfg_irq_sel = 7'd55;
      arm();
      w0 = n_wr; i0 = n_irq;
      for (int k = 0; k < 7; k++) req_pulse(55);
      chk(n_wr == w0 + 5, "R7 one-shot stops after block", n_wr, w0 + 5);
      chk(n_irq == i0 + 1, "R11 single half-block irq", n_irq, i0 + 1);
      chk(last_wr_addr == 12'h205, "R4 byte step of 1", 32'(last_wr_addr), 32'h205);
      chk(chan_en == 1'b0, "R7 channel disabled", 32'(chan_en), 0);

      // force held while disabled (R6)
      force_pulse();
      chk(force_pend == 1'b1, "R6 force held while disabled", 32'(force_pend), 1);
      w0 = n_wr;
      cfg_dir = 0; cfg_byte = 1; cfg_inc = 0; cfg_mode = 2'd1; cfg_half = 0;
      cfg_start_a = 12'h055; cfg_count = 10'd2;
      arm();
      repeat (4) @(negedge clk);
      chk(force_pend == 1'b0, "R6 force self-clears", 32'(force_pend), 0);
      chk(n_wr == w0 + 1, "R6 forced transfer done", n_wr, w0 + 1);

      // no increment with forced transfers (R4)
      force_pulse();
      force_pulse();
      chk(last_wr_addr == 12'h055, "R4 address held", 32'(last_wr_addr), 32'h055);
      chk(n_wr == w0 + 3, "R6 each force moves one element", n_wr, w0 + 3);

      // ping-pong word blocks of 2 (R9)
      cfg_dir = 0; cfg_byte = 0; cfg_inc = 1; cfg_mode = 2'd2;
      cfg_start_a = 12'h300; cfg_start_b = 12'h340; cfg_count = 10'd1; cfg_irq_sel = 7'd0;
      arm();
      req_pulse(0); req_pulse(0);
      chk(pp_last == 1'b0, "R9 buffer A finished", 32'(pp_last), 0);
      req_pulse(0);
      chk(last_wr_addr == 12'h340, "R9 second block at B", 32'(last_wr_addr), 32'h340);
      req_pulse(0);
      chk(pp_last == 1'b1, "R9 buffer B finished", 32'(pp_last), 1);
      req_pulse(0);
      chk(last_wr_addr == 12'h300, "R9 back to A", 32'(last_wr_addr), 32'h300);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule